// File: doc/BRIEF.md
# Active-Low Byte Handshake Engine

This block carries bytes between a host and an on-chip controller through one shift-data register. The host owns two active-low lines in an 8-bit port register: transfer-in-progress (bit 5) and acknowledge (bit 4). The engine owns the active-low request line (bit 3) of the same register. Bit 4 of an auxiliary control byte picks the direction. When it is 1, the host shifts bytes out into a small outbound buffer. When it is 0, the host reads bytes from a larger inbound buffer that the controller fills and then arms with a length.

The engine acts only in a cycle where the host writes the port register, or the controller arms an inbound packet. It compares the new levels of the in-progress and acknowledge lines with the levels from the previous port write. One enumerated phase register remembers whether the last write left a transfer open. The phases are ST_IDLE, ST_XFER_OUT and ST_XFER_IN. On a port write with in-progress low, the phase moves to ST_XFER_OUT when the direction bit is 1 and to ST_XFER_IN when it is 0. On a port write with in-progress high, the phase moves to ST_IDLE. Without a port write, the phase holds.

Each byte step, each end of transfer and each idle acknowledge toggle sets a shift-complete flag. When a host-out packet ends with at least one byte captured, the engine pulses packet-done with the byte count, and the controller can then read the bytes.

Top module: `shift_hs_engine`

## Requirements
- R1: After reset, `port_rdata` reads 8'h38 (in-progress, acknowledge and request all high), `shift_flag` is 0, `pkt_done` is 0 and `sr_q` is 0.
- R2: After a port write, `port_rdata` returns the written bits except bit 3, which always shows the engine's request level (1 = deasserted).
- R3: While the written in-progress bit is 0 and the direction bit (`aux_ctrl` bit 4) is 1, a write that changes the {acknowledge, in-progress} pair from the previous write stores `sr_q` into the next outbound slot and sets `shift_flag`. A write that leaves the pair unchanged stores nothing.
- R4: Once OUT_DEPTH bytes are held, further outbound steps are dropped and do not set `shift_flag`. `pkt_len` never exceeds OUT_DEPTH.
- R5: While in-progress is 0 and the direction bit is 0, a pair change loads the next unread inbound byte into `sr_q` and sets `shift_flag`. When no unread bytes remain, `sr_q` and `shift_flag` are left untouched.
- R6: Loading the last inbound byte drives request high (bit 3 = 1).
- R7: When in-progress is 1 in both the previous and the new write and acknowledge changes, request takes the new acknowledge level and `shift_flag` is set.
- R8: A write that raises in-progress after a transfer always sets `shift_flag`. If any outbound bytes were captured, `pkt_done` is high for one cycle with `pkt_len` equal to their count, and the outbound index returns to 0.
- R9: A write with in-progress 1 that is not an idle acknowledge toggle drives request low whenever unread inbound bytes remain.
- R10: An `in_load` pulse (never together with `port_wr`) sets the read index to 0 and the length to `in_len`, and sets `shift_flag`. In ST_IDLE with a nonzero length it also drives request low. During a transfer it leaves request unchanged.
- R11: A `flag_clr` pulse with no flag-setting event in the same cycle clears `shift_flag`.
- R12: `sr_wr` loads `sr_wdata` into `sr_q` unless an inbound byte is loaded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_wr | input | 1 | Host writes the port register this cycle |
| port_wdata | input | 8 | Port value written by the host (bit 3 ignored) |
| port_rdata | output | 8 | Port register readback including the request line |
| aux_ctrl | input | 8 | Auxiliary control byte; bit 4 = 1 selects host-out |
| sr_wr | input | 1 | Host writes the shift register |
| sr_wdata | input | DATA_W | Shift register write data |
| sr_q | output | DATA_W | Shift register contents |
| flag_clr | input | 1 | Clears the shift-complete flag |
| shift_flag | output | 1 | Shift-complete interrupt flag |
| in_wr | input | 1 | Controller writes one inbound buffer byte |
| in_waddr | input | IN_AW | Inbound buffer write address |
| in_wdata | input | DATA_W | Inbound buffer write data |
| in_load | input | 1 | Arms an inbound packet of `in_len` bytes |
| in_len | input | IN_CW | Inbound packet length |
| out_raddr | input | OUT_AW | Outbound buffer read address |
| out_rdata | output | DATA_W | Outbound buffer read data |
| pkt_done | output | 1 | One-cycle pulse when a host-out packet ends |
| pkt_len | output | OUT_CW | Byte count of the finished host-out packet |

## Verification
The bench builds the engine with its default sizes: an 8-bit data path, a 16-slot outbound buffer and a 128-slot inbound buffer. With 16 outbound slots, a 20-byte host-out packet reaches the overflow boundary. That packet shows the seventeenth step dropped without a flag and a count capped at 16. Short inbound packets cover the other cases: the last-byte request release, reads past the end, rearming during an open transfer, and the read-index reset when a new packet is loaded.

// File: rtl/shs_pkg.sv
package shs_pkg;
    // Line positions inside the port register; the host depends on them.
    localparam int REQ_POS = 3;
    localparam int ACK_POS = 4;
    localparam int TIP_POS = 5;
    localparam logic [7:0] REQ_MASK = 8'h08;
    localparam logic [7:0] DIR_MASK = 8'h10;
    localparam logic [7:0] PORT_RESET = 8'h30;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_XFER_OUT = 2'd1,
        ST_XFER_IN  = 2'd2
    } hs_state_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic req_hi;
        logic req_lo;
        logic req_copy;
        logic flag_set;
        logic pkt_fire;
    } hs_ev_t;
endpackage

// File: rtl/shs_out_buf.sv
module shs_out_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          full,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          do_push;

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (do_push) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[cnt_q[AW-1:0]] <= din;
        end
    end

    assign count = cnt_q;
    assign rdata = mem[raddr];
endmodule

// File: rtl/shs_in_buf.sv
module shs_in_buf #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          load,
    input  logic [CW-1:0] load_len,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          avail,
    output logic          last
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] idx_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] len_clamped;

    assign len_clamped = (load_len > CW'(DEPTH)) ? CW'(DEPTH) : load_len;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (load) begin
            idx_q <= '0;
            len_q <= len_clamped;
        end else if (pop && avail) begin
            idx_q <= idx_q + CW'(1);
        end
    end

    assign avail = (idx_q < len_q);
    assign last  = avail && ((idx_q + CW'(1)) == len_q);
    assign rdata = mem[idx_q[AW-1:0]];
endmodule

// File: rtl/shs_decode.sv
module shs_decode
    import shs_pkg::*;
(
    input  hs_state_t st,
    input  logic      wr,
    input  logic      new_tip_n,
    input  logic      new_ack_n,
    input  logic      prev_ack_n,
    input  logic      dir_out,
    input  logic      out_full,
    input  logic      out_any,
    input  logic      in_avail,
    input  logic      in_last,
    output hs_ev_t    ev
);
    logic prev_tip_n;
    logic ack_chg;
    logic pair_chg;

    always_comb begin
        unique case (st)
            ST_IDLE:     prev_tip_n = 1'b1;
            ST_XFER_OUT: prev_tip_n = 1'b0;
            ST_XFER_IN:  prev_tip_n = 1'b0;
            default:     prev_tip_n = 1'b1;
        endcase
    end

    assign ack_chg  = (new_ack_n != prev_ack_n);
    assign pair_chg = ack_chg || (new_tip_n != prev_tip_n);

    always_comb begin
        ev = '0;
        if (wr) begin
            if (!new_tip_n) begin
                if (dir_out) begin
                    if (pair_chg && !out_full) begin
                        ev.push     = 1'b1;
                        ev.flag_set = 1'b1;
                    end
                end else if (pair_chg && in_avail) begin
                    ev.pop      = 1'b1;
                    ev.flag_set = 1'b1;
                    ev.req_hi   = in_last;
                end
            end else if (prev_tip_n && ack_chg) begin
                ev.req_copy = 1'b1;
                ev.flag_set = 1'b1;
            end else begin
                if (!prev_tip_n) begin
                    ev.flag_set = 1'b1;
                    ev.pkt_fire = out_any;
                end
                ev.req_lo = in_avail;
            end
        end
    end
endmodule

// File: rtl/shift_hs_engine.sv
module shift_hs_engine
    import shs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OUT_DEPTH = 16,
    parameter int IN_DEPTH  = 128,
    localparam int OUT_AW   = $clog2(OUT_DEPTH),
    localparam int OUT_CW   = $clog2(OUT_DEPTH + 1),
    localparam int IN_AW    = $clog2(IN_DEPTH),
    localparam int IN_CW    = $clog2(IN_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [7:0]        port_wdata,
    output logic [7:0]        port_rdata,
    input  logic [7:0]        aux_ctrl,
    input  logic              sr_wr,
    input  logic [DATA_W-1:0] sr_wdata,
    output logic [DATA_W-1:0] sr_q,
    input  logic              flag_clr,
    output logic              shift_flag,
    input  logic              in_wr,
    input  logic [IN_AW-1:0]  in_waddr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_load,
    input  logic [IN_CW-1:0]  in_len,
    input  logic [OUT_AW-1:0] out_raddr,
    output logic [DATA_W-1:0] out_rdata,
    output logic              pkt_done,
    output logic [OUT_CW-1:0] pkt_len
);
    hs_state_t         st_q, st_d;
    hs_ev_t            ev;
    logic [7:0]        port_q;
    logic              req_n_q;
    logic [DATA_W-1:0] sr_r;
    logic              flag_q;
    logic              pkt_done_q;
    logic [OUT_CW-1:0] pkt_len_q;
    logic              dir_out;
    logic              load_req_lo;

    logic [OUT_CW-1:0] out_cnt;
    logic              out_full;
    logic [DATA_W-1:0] in_rdata;
    logic              in_avail;
    logic              in_last;

    assign dir_out     = ((aux_ctrl & DIR_MASK) != 8'h00);
    assign load_req_lo = in_load && (st_q == ST_IDLE) && (in_len != '0);

    shs_decode u_dec (
        .st         (st_q),
        .wr         (port_wr),
        .new_tip_n  (port_wdata[TIP_POS]),
        .new_ack_n  (port_wdata[ACK_POS]),
        .prev_ack_n (port_q[ACK_POS]),
        .dir_out    (dir_out),
        .out_full   (out_full),
        .out_any    (out_cnt != '0),
        .in_avail   (in_avail),
        .in_last    (in_last),
        .ev         (ev)
    );

    shs_out_buf #(.DEPTH(OUT_DEPTH), .W(DATA_W)) u_obuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ev.push),
        .din   (sr_r),
        .clr   (ev.pkt_fire),
        .count (out_cnt),
        .full  (out_full),
        .raddr (out_raddr),
        .rdata (out_rdata)
    );

    shs_in_buf #(.DEPTH(IN_DEPTH), .W(DATA_W)) u_ibuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_wr),
        .waddr    (in_waddr),
        .wdata    (in_wdata),
        .load     (in_load),
        .load_len (in_len),
        .pop      (ev.pop),
        .rdata    (in_rdata),
        .avail    (in_avail),
        .last     (in_last)
    );

    // Phase register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_XFER_OUT, ST_XFER_IN: begin
                if (port_wr) begin
                    if (!port_wdata[TIP_POS]) begin
                        st_d = dir_out ? ST_XFER_OUT : ST_XFER_IN;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Output and data registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q     <= PORT_RESET;
            req_n_q    <= 1'b1;
            sr_r       <= '0;
            flag_q     <= 1'b0;
            pkt_done_q <= 1'b0;
            pkt_len_q  <= '0;
        end else begin
            pkt_done_q <= ev.pkt_fire;
            if (ev.pkt_fire) begin
                pkt_len_q <= out_cnt;
            end
            if (port_wr) begin
                port_q <= port_wdata & ~REQ_MASK;
            end
            if (ev.req_hi) begin
                req_n_q <= 1'b1;
            end else if (ev.req_copy) begin
                req_n_q <= port_wdata[ACK_POS];
            end else if (ev.req_lo || load_req_lo) begin
                req_n_q <= 1'b0;
            end
            if (ev.pop) begin
                sr_r <= in_rdata;
            end else if (sr_wr) begin
                sr_r <= sr_wdata;
            end
            if (ev.flag_set || in_load) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign port_rdata = port_q | ({7'd0, req_n_q} << REQ_POS);
    assign sr_q       = sr_r;
    assign shift_flag = flag_q;
    assign pkt_done   = pkt_done_q;
    assign pkt_len    = pkt_len_q;
endmodule

// File: rtl/shs_checker.sv
module shs_checker #(
    parameter int DATA_W    = 8,
    parameter int OUT_DEPTH = 16,
    localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_wr,
    input logic              w_tip,
    input logic              w_ack,
    input logic              r_tip,
    input logic              r_ack,
    input logic              r_req,
    input logic              in_load,
    input logic              flag_clr,
    input logic              sr_wr,
    input logic [DATA_W-1:0] sr_wdata,
    input logic [DATA_W-1:0] sr_q,
    input logic              shift_flag,
    input logic              pkt_done,
    input logic [OUT_CW-1:0] pkt_len
);
    AST_TIP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (r_tip == $past(w_tip)));  // R2

    AST_RELEASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !r_tip && w_tip) |=> shift_flag);  // R8

    AST_PKT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> ($past(port_wr) && $past(w_tip) && !$past(r_tip)));  // R8

    AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len != '0 && pkt_len <= OUT_CW'(OUT_DEPTH)));  // R4

    AST_SYNC_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && r_tip && w_tip && (w_ack != r_ack)) |=> (r_req == $past(w_ack)));  // R7

    AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_load |=> shift_flag);  // R10

    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr && in_load));  // R10

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !port_wr && !in_load) |=> !shift_flag);  // R11

    AST_SR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && !port_wr) |=> (sr_q == $past(sr_wdata)));  // R12
endmodule

bind shift_hs_engine shs_checker #(.DATA_W(DATA_W), .OUT_DEPTH(OUT_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_wr    (port_wr),
    .w_tip      (port_wdata[5]),
    .w_ack      (port_wdata[4]),
    .r_tip      (port_rdata[5]),
    .r_ack      (port_rdata[4]),
    .r_req      (port_rdata[3]),
    .in_load    (in_load),
    .flag_clr   (flag_clr),
    .sr_wr      (sr_wr),
    .sr_wdata   (sr_wdata),
    .sr_q       (sr_q),
    .shift_flag (shift_flag),
    .pkt_done   (pkt_done),
    .pkt_len    (pkt_len)
);

// File: tb/shift_hs_engine_tb_top.sv
module shift_hs_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_wr = 1'b0;
    logic [7:0] port_wdata = 8'h38;
    logic [7:0] port_rdata;
    logic [7:0] aux_ctrl = 8'h00;
    logic       sr_wr = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic [7:0] sr_q;
    logic       flag_clr = 1'b0;
    logic       shift_flag;
    logic       in_wr = 1'b0;
    logic [6:0] in_waddr = '0;
    logic [7:0] in_wdata = '0;
    logic       in_load = 1'b0;
    logic [7:0] in_len = '0;
    logic [3:0] out_raddr = '0;
    logic [7:0] out_rdata;
    logic       pkt_done;
    logic [4:0] pkt_len;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shift_hs_engine dut_i (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .aux_ctrl(aux_ctrl), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .sr_q(sr_q), .flag_clr(flag_clr),
        .shift_flag(shift_flag), .in_wr(in_wr), .in_waddr(in_waddr),
        .in_wdata(in_wdata), .in_load(in_load), .in_len(in_len),
        .out_raddr(out_raddr), .out_rdata(out_rdata), .pkt_done(pkt_done),
        .pkt_len(pkt_len)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic port_write(input logic [7:0] v);
        @(negedge clk); port_wr = 1'b1; port_wdata = v;
        @(negedge clk); port_wr = 1'b0;
    endtask

    task automatic sr_write(input logic [7:0] v);
        @(negedge clk); sr_wr = 1'b1; sr_wdata = v;
        @(negedge clk); sr_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic fill_in(input int idx, input logic [7:0] v);
        @(negedge clk); in_wr = 1'b1; in_waddr = 7'(idx); in_wdata = v;
        @(negedge clk); in_wr = 1'b0;
    endtask

    task automatic arm_in(input int n);
        @(negedge clk); in_load = 1'b1; in_len = 8'(n);
        @(negedge clk); in_load = 1'b0;
    endtask

    task automatic read_out(input int a, input logic [7:0] exp, input string tag);
        out_raddr = 4'(a);
        #1;
        check(tag, out_rdata, exp);
    endtask

    task automatic t_reset();
        check("R1 port reset", port_rdata, 8'h38);
        check("R1 flag reset", shift_flag, 0);
        check("R1 pkt_done reset", pkt_done, 0);
        check("R1 sr reset", sr_q, 0);
    endtask

    task automatic t_host_out();
        aux_ctrl = 8'h10;
        sr_write(8'hA0);
        check("R12 sr write", sr_q, 8'hA0);
        clear_flag();
        check("R11 flag cleared", shift_flag, 0);
        port_write(8'h18);
        check("R3 first capture flag", shift_flag, 1);
        check("R2 readback", port_rdata, 8'h18);
        sr_write(8'hA1); port_write(8'h08);
        sr_write(8'hA2); port_write(8'h18);
        clear_flag();
        sr_write(8'hFF); port_write(8'h18);
        check("R3 no capture without change", shift_flag, 0);
        port_write(8'h38);
        check("R8 pkt_done pulse", pkt_done, 1);
        check("R8 pkt_len", pkt_len, 3);
        check("R8 release flag", shift_flag, 1);
        read_out(0, 8'hA0, "R3 slot0");
        read_out(1, 8'hA1, "R3 slot1");
        read_out(2, 8'hA2, "R3 slot2");
        @(negedge clk);
        check("R8 pkt_done one cycle", pkt_done, 0);
    endtask

    task automatic t_overflow();
        aux_ctrl = 8'h10;
        for (int i = 0; i < 20; i++) begin
            sr_write(8'h40 + 8'(i));
            if (i == 16) clear_flag();
            port_write((i % 2 == 0) ? 8'h18 : 8'h08);
            if (i == 16) check("R4 dropped step no flag", shift_flag, 0);
        end
        port_write(8'h38);
        check("R4 pkt_len capped", pkt_len, 16);
        check("R4 pkt_done", pkt_done, 1);
        read_out(15, 8'h4F, "R4 last kept slot");
        read_out(0, 8'h40, "R4 first slot");
    endtask

    task automatic t_host_in();
        aux_ctrl = 8'h00;
        fill_in(0, 8'hC1); fill_in(1, 8'hC2); fill_in(2, 8'hC3);
        clear_flag();
        arm_in(3);
        check("R10 load flag", shift_flag, 1);
        check("R10 idle load request low", port_rdata[3], 0);
        clear_flag();
        port_write(8'h18);
        check("R5 byte0", sr_q, 8'hC1);
        check("R5 byte0 flag", shift_flag, 1);
        port_write(8'h08);
        check("R5 byte1", sr_q, 8'hC2);
        check("R6 request still low", port_rdata[3], 0);
        port_write(8'h18);
        check("R5 byte2", sr_q, 8'hC3);
        check("R6 request high on last", port_rdata[3], 1);
        clear_flag();
        port_write(8'h08);
        check("R5 exhausted sr kept", sr_q, 8'hC3);
        check("R5 exhausted no flag", shift_flag, 0);
        port_write(8'h38);
        check("R8 release flag host-in", shift_flag, 1);
        check("R8 no pkt_done without bytes", pkt_done, 0);
    endtask

    task automatic t_sync();
        clear_flag();
        port_write(8'h28);
        check("R7 request copies low ack", port_rdata[3], 0);
        check("R7 flag", shift_flag, 1);
        clear_flag();
        port_write(8'h38);
        check("R7 request copies high ack", port_rdata[3], 1);
        check("R7 flag again", shift_flag, 1);
    endtask

    task automatic t_rearm();
        aux_ctrl = 8'h00;
        port_write(8'h18);
        fill_in(0, 8'hD1); fill_in(1, 8'hD2);
        clear_flag();
        arm_in(2);
        check("R10 active load keeps request", port_rdata[3], 1);
        check("R10 active load flag", shift_flag, 1);
        port_write(8'h08);
        check("R5 first byte after rearm", sr_q, 8'hD1);
        port_write(8'h28);
        check("R9 unread remain request low", port_rdata[3], 0);
        fill_in(0, 8'hE5);
        arm_in(1);
        port_write(8'h08);
        check("R10 index reset", sr_q, 8'hE5);
        check("R6 single byte request high", port_rdata[3], 1);
        port_write(8'h28);
        check("R9 nothing unread request stays high", port_rdata[3], 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_host_out();
        t_overflow();
        t_host_in();
        t_sync();
        t_rearm();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule